// File: doc/BRIEF.md
# Set-Reset Edge Phase Detector

This block compares two logic-level clocks that are asynchronous to the system clock. A rising edge on the reference input drives the detector output high, and a rising edge on the feedback input drives it low. The fraction of time the output is high therefore tracks the phase lag of feedback behind reference, linearly across a full turn. A lag of half a period gives a half-high output. The block acts only on rising transitions, so the pulse widths of the two inputs have no effect.

Both inputs pass through multi-flop synchronizers and rising-edge detectors in the system clock domain. A meter counts the system clocks for which the set-reset state stays high. It reports that count with a one-cycle strobe each time the state is cleared from high. A watchdog on the reference input forces the output high when reference edges stop arriving. A downstream loop then drives its oscillator toward the top of its range. Filtering and oscillator control are outside the block.

Top module: `rsff_phase_det`

## Requirements
- R1: While `rst_n` is low, and for the two clocks of synchronous reset release after it rises, `pd_out` and `meas_valid` are low and `meas_count` is zero.
- R2: A rising edge on `ref_in` sets the detector. If `ref_in` rises just before clock edge k, `pd_out` is high after clock edge k+2, which is two synchronizer flops plus the state register.
- R3: A rising edge on `fb_in` clears the detector with the same latency. If `fb_in` rises D clock cycles after `ref_in`, `pd_out` is high for exactly D clock cycles.
- R4: The high and low widths of `ref_in` and `fb_in` have no effect on `pd_out` or on the measurement. Only rising transitions count.
- R5: When reference and feedback rising edges are detected in the same clock cycle, the detector ends up cleared. If it was already clear, no measurement is reported.
- R6: A further reference rising edge while the detector is set leaves the state and the running count unchanged. A feedback rising edge while the detector is clear produces no measurement.
- R7: When the detector is cleared from high, `meas_count` carries the number of clocks the state was high and `meas_valid` is high for exactly one cycle. That cycle is the first cycle in which the state is low. `meas_count` holds its value otherwise.
- R8: The measured count saturates at 2^CNT_W-1 and does not wrap.
- R9: With both inputs periodic and feedback lagging by half a period, `pd_out` is high for half of each period, and each measurement equals half the period in clocks.
- R10: If no reference rising edge is detected for LOSS_CYC consecutive cycles, `pd_out` is forced high. The next reference rising edge removes the override. The set-reset state and the measurement do not depend on the override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_in | input | 1 | Reference clock, asynchronous |
| fb_in | input | 1 | Feedback clock from the oscillator divider, asynchronous |
| pd_out | output | 1 | Detector output: high means speed up |
| meas_count | output | CNT_W | Clocks spent high in the last completed set interval |
| meas_valid | output | 1 | One-cycle strobe marking a new `meas_count` |

## Verification
The assertions assume that each input stays steady for at least one system clock after it changes. Under that assumption every transition reaches the edge detectors, and two rising edges on the same input are never closer than two cycles. The bench drives both inputs only on falling clock edges and holds each level for whole cycles. It keeps the interval between reference edges below LOSS_CYC except in the scenario that tests reference loss. The checks on the set and clear properties rely on edges that the synchronizers have already detected, so they make no assumption about metastability timing.

// File: rtl/rspd_pkg.sv
package rspd_pkg;

  // Event seen by the set-reset core in one system clock cycle
  typedef enum logic [1:0] {
    EV_NONE = 2'b00,
    EV_SET  = 2'b01,
    EV_CLR  = 2'b10,
    EV_BOTH = 2'b11
  } rspd_evt_e;

  function automatic rspd_evt_e rspd_classify(input logic set_rise, input logic clr_rise);
    rspd_evt_e evt;
    unique case ({clr_rise, set_rise})
      2'b01:   evt = EV_SET;
      2'b10:   evt = EV_CLR;
      2'b11:   evt = EV_BOTH;
      default: evt = EV_NONE;
    endcase
    return evt;
  endfunction

endpackage

// File: rtl/rspd_rst_sync.sv
module rspd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/rspd_edge_sync.sv
module rspd_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic din,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  always_comb begin
    sync_d[0] = din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_comb begin
      sync_d[s] = sync_q[s-1];
    end
  end

  always_comb begin
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/rspd_rs_core.sv
module rspd_rs_core
  import rspd_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic set_rise,
  input  logic clr_rise,
  output logic q_o,
  output logic start_o,
  output logic stop_o
);
  rspd_evt_e evt;
  logic      q_q;
  logic      q_d;
  logic      q_en;

  always_comb begin
    evt  = rspd_classify(set_rise, clr_rise);
    q_d  = q_q;
    unique case (evt)
      EV_SET:          q_d = 1'b1;
      EV_CLR, EV_BOTH: q_d = 1'b0;
      default:         q_d = q_q;
    endcase
    q_en = (q_d != q_q);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)   q_q <= 1'b0;
    else if (q_en) q_q <= q_d;
  end

  assign q_o     = q_q;
  assign start_o = ~q_q & (evt == EV_SET);
  assign stop_o  = q_q & ((evt == EV_CLR) | (evt == EV_BOTH));
endmodule

// File: rtl/rspd_meter.sv
module rspd_meter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic [CNT_W-1:0] count_o,
  output logic             valid_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [CNT_W-1:0] rep_q, rep_d;
  logic             rep_en;
  logic             vld_q, vld_d;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (start_i) begin
      cnt_d  = CNT_ONE;
      cnt_en = 1'b1;
    end else if (run_i && !stop_i && (cnt_q != CNT_MAX)) begin
      cnt_d  = cnt_q + CNT_ONE;
      cnt_en = 1'b1;
    end
    rep_d  = cnt_q;
    rep_en = stop_i;
    vld_d  = stop_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rep_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (rep_en) rep_q <= rep_d;
      vld_q <= vld_d;
    end
  end

  assign count_o = rep_q;
  assign valid_o = vld_q;
endmodule

// File: rtl/rspd_ref_watch.sv
module rspd_ref_watch #(
  parameter int unsigned LOSS_CYC = 64
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic ref_rise,
  output logic lost_o
);
  localparam int unsigned TMO_W = (LOSS_CYC > 1) ? $clog2(LOSS_CYC) : 1;
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(LOSS_CYC - 1);

  logic [TMO_W-1:0] tmo_q, tmo_d;
  logic             tmo_en;
  logic             lost_q, lost_d;
  logic             lost_en;

  always_comb begin
    tmo_d   = tmo_q;
    tmo_en  = 1'b0;
    lost_d  = lost_q;
    lost_en = 1'b0;
    if (ref_rise) begin
      tmo_d   = '0;
      tmo_en  = 1'b1;
      lost_d  = 1'b0;
      lost_en = 1'b1;
    end else if (!lost_q) begin
      if (tmo_q == TMO_LAST) begin
        lost_d  = 1'b1;
        lost_en = 1'b1;
      end else begin
        tmo_d  = tmo_q + TMO_W'(1);
        tmo_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      if (tmo_en)  tmo_q  <= tmo_d;
      if (lost_en) lost_q <= lost_d;
    end
  end

  assign lost_o = lost_q;
endmodule

// File: rtl/rsff_phase_det.sv
module rsff_phase_det #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned LOSS_CYC    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             fb_in,
  output logic             pd_out,
  output logic [CNT_W-1:0] meas_count,
  output logic             meas_valid
);
  logic rst_sync_n;
  logic ref_rise;
  logic fb_rise;
  logic core_q;
  logic core_start;
  logic core_stop;
  logic ref_lost;

  rspd_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_ni (rst_n),
    .rst_no  (rst_sync_n)
  );

  rspd_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .din    (ref_in),
    .rise_o (ref_rise)
  );

  rspd_edge_sync #(.STAGES(SYNC_STAGES)) u_fb_sync (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .din    (fb_in),
    .rise_o (fb_rise)
  );

  rspd_rs_core u_core (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .set_rise (ref_rise),
    .clr_rise (fb_rise),
    .q_o      (core_q),
    .start_o  (core_start),
    .stop_o   (core_stop)
  );

  rspd_meter #(.CNT_W(CNT_W)) u_meter (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .run_i   (core_q),
    .start_i (core_start),
    .stop_i  (core_stop),
    .count_o (meas_count),
    .valid_o (meas_valid)
  );

  rspd_ref_watch #(.LOSS_CYC(LOSS_CYC)) u_watch (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .ref_rise (ref_rise),
    .lost_o   (ref_lost)
  );

  assign pd_out = core_q | ref_lost;
endmodule

// File: rtl/rspd_chk.sv
module rspd_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             ref_rise,
  input logic             fb_rise,
  input logic             core_q,
  input logic             ref_lost,
  input logic             pd_out,
  input logic [CNT_W-1:0] meas_count,
  input logic             meas_valid
);
  assert_set_on_ref_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (ref_rise && !fb_rise) |=> core_q);

  assert_clear_on_fb_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (fb_rise && !ref_rise) |=> !core_q);

  assert_both_clear_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (ref_rise && fb_rise) |=> !core_q);

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    meas_valid |=> !meas_valid);

  assert_valid_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    meas_valid |-> ($past(core_q) && !core_q));

  assert_count_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    meas_valid |-> (meas_count != '0));

  assert_lost_forces_high_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    ref_lost |-> pd_out);

  assert_core_drives_out_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    core_q |-> pd_out);
endmodule

bind rsff_phase_det rspd_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_ni     (rst_sync_n),
  .ref_rise   (ref_rise),
  .fb_rise    (fb_rise),
  .core_q     (core_q),
  .ref_lost   (ref_lost),
  .pd_out     (pd_out),
  .meas_count (meas_count),
  .meas_valid (meas_valid)
);

// File: tb/rsff_phase_det_tb.sv
module rsff_phase_det_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 4;
  localparam int LOSS_CYC   = 64;
  localparam int WD_CYCLES  = 20000;

  logic             clk;
  logic             rst_n;
  logic             ref_in;
  logic             fb_in;
  logic             pd_out;
  logic [CNT_W-1:0] meas_count;
  logic             meas_valid;

  int checks;
  int errors;
  bit done;

  rsff_phase_det #(.SYNC_STAGES(2), .CNT_W(CNT_W), .LOSS_CYC(LOSS_CYC)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_in     (ref_in),
    .fb_in      (fb_in),
    .pd_out     (pd_out),
    .meas_count (meas_count),
    .meas_valid (meas_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drives ref rising at step 0 (width ref_w, optional second rise at r2_at),
  // fb rising at step d (width fb_w); counts pd_out-high samples and strobes.
  task automatic phase_run(input string req, input int d, input int ref_w, input int fb_w,
                           input int r2_at, input int exp_hi, input int exp_nv,
                           input int exp_cnt);
    int hi = 0;
    int nv = 0;
    int cnt = -1;
    int win = d + ref_w + fb_w + r2_at + 10;
    for (int k = 0; k <= win; k++) begin
      @(negedge clk);
      if (pd_out) hi++;
      if (meas_valid) begin
        nv++;
        cnt = int'(meas_count);
      end
      ref_in = (k < ref_w) || (r2_at > 0 && k >= r2_at && k < r2_at + 2);
      fb_in  = (k >= d) && (k < d + fb_w);
    end
    chk(req, "pd_out high cycles", hi, exp_hi);
    chk(req, "valid strobes", nv, exp_nv);
    if (exp_nv > 0) chk(req, "measured count", cnt, exp_cnt);
    chk(req, "pd_out after run", int'(pd_out), 0);
  endtask

  task automatic t_reset();
    ref_in = 1'b0;
    fb_in  = 1'b0;
    rst_n  = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1", "pd_out in reset", int'(pd_out), 0);
    chk("R1", "meas_valid in reset", int'(meas_valid), 0);
    chk("R1", "meas_count in reset", int'(meas_count), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "pd_out after release", int'(pd_out), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_lag_wide();      // R2 R3 R7: wide ref pulse, lag 5
    phase_run("R3", 5, 9, 9, 0, 5, 1, 5);
  endtask

  task automatic t_lag_narrow();    // R4: one-cycle pulses, lag 12
    phase_run("R4", 12, 1, 1, 0, 12, 1, 12);
  endtask

  task automatic t_lag_one();       // R2: minimum lag
    phase_run("R2", 1, 1, 3, 0, 1, 1, 1);
  endtask

  task automatic t_coincident();    // R5: edges in the same cycle
    phase_run("R5", 0, 2, 2, 0, 0, 0, 0);
  endtask

  task automatic t_retrigger();     // R6: second ref rise while set
    phase_run("R6", 10, 2, 2, 5, 10, 1, 10);
  endtask

  task automatic t_fb_alone();      // R6: fb rise while clear
    int hi = 0;
    int nv = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (pd_out) hi++;
      if (meas_valid) nv++;
      fb_in = (k >= 1 && k < 4);
    end
    chk("R6", "pd_out high on lone fb", hi, 0);
    chk("R6", "valid on lone fb", nv, 0);
  endtask

  task automatic t_periodic();      // R9: half-period lag, 16-cycle period
    int hi = 0;
    int nv = 0;
    int bad = 0;
    for (int k = 0; k < 58; k++) begin
      @(negedge clk);
      if (pd_out) hi++;
      if (meas_valid) begin
        nv++;
        if (int'(meas_count) != 8) bad++;
      end
      ref_in = (k < 48) && ((k % 16) < 8);
      fb_in  = (k >= 8) && (k < 48) && (((k + 8) % 16) < 8);
    end
    chk("R9", "high cycles over 3 periods", hi, 24);
    chk("R9", "strobes over 3 periods", nv, 3);
    chk("R9", "measurements not equal 8", bad, 0);
  endtask

  task automatic t_saturate();      // R8: lag 20 with 4-bit count
    phase_run("R8", 20, 2, 2, 0, 20, 1, 15);
  endtask

  task automatic t_ref_loss();      // R10
    repeat (10) @(negedge clk);
    chk("R10", "pd_out before timeout", int'(pd_out), 0);
    fb_in = 1'b1;
    repeat (3) @(negedge clk);
    fb_in = 1'b0;
    repeat (40) @(negedge clk);
    chk("R10", "pd_out forced high", int'(pd_out), 1);
    chk("R10", "no strobe while forced", int'(meas_valid), 0);
    // forced for steps 0..2, then set state for 4 cycles
    phase_run("R10", 4, 2, 2, 0, 7, 1, 4);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    t_reset();
    t_lag_wide();
    t_lag_narrow();
    t_lag_one();
    t_coincident();
    t_retrigger();
    t_fb_alone();
    t_periodic();
    t_saturate();
    t_ref_loss();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule